// File: doc/BRIEF.md
# Two-Channel Hardware Breakpoint Unit

This block sits beside a CPU and watches its bus. Each of two comparator channels compares the bus address and the kind of cycle (instruction fetch, data read, data write) against a programmed pattern. A channel that matches sets its own sticky flag. Depending on its configuration, it also asks the CPU to break, either before or after the matching instruction executes. Several break requests are merged into one registered pulse. A CPU-side block input suppresses delivery of that pulse, but matching and flag setting continue while the input is high.

Two extra modes build on the channels. In sequence mode, one channel is chosen as the first stage. A break is then requested only when the other channel matches while the first stage's flag is still set, and clearing that flag disarms the sequence. In count mode, channel 1 carries a down-counter. The counter decrements on each channel-1 match, and channel 1 requests a break only on the match that takes the counter from one to zero. Software programs everything through a small register port, and read data is registered.

Top module: `brk_unit`

## Requirements
- R1: A channel matches on a cycle with `bus_valid` high only when its enable (CTRL bit 0) is set, `bus_addr` equals its address register, and the kind mask in CTRL bits [6:4] allows the bus kind. Bit 4 allows fetch (`bus_kind`=1), bit 5 allows read (2) and bit 6 allows write (3). Kind 0 never matches.
- R2: The FLAGS register (offset 6) holds channel 0 in bit 0 and channel 1 in bit 1. A match sets its channel's flag. Writing 0 to a flag bit clears it, and writing 1 to it has no effect. A match in the same cycle as a clear leaves the flag set.
- R3: A match raises a break request only if the channel's request enable (CTRL bit 1) is set. The flag is set either way.
- R4: With a request, `brk_after` carries the timing bit (CTRL bit 2) of the requesting channel. Channel 0 wins when both channels request.
- R5: When both channels request in the same cycle, a single one-cycle pulse is produced and both flags are set.
- R6: While `bus_blocked` is high during the bus cycle, no break pulse is produced, but flags are still set.
- R7: In sequence mode (MODE bit 0), MODE bit 1 selects the first stage (0 selects channel 0, 1 selects channel 1). The first stage never requests a break. The second stage requests only if the first stage's flag was already set before its match.
- R8: Clearing the first stage's flag disarms the sequence, so a later second-stage match requests no break.
- R9: In count mode (MODE bit 2), every channel-1 match decrements the counter (offset 5) while it is nonzero. Channel 1 requests a break only on the match that takes the counter from 1 to 0, and never while it is 0. A register write to the counter takes priority over a decrement.
- R10: `brk_req` is a registered pulse. It is high in the cycle after the qualifying bus cycle and low in the following cycle unless another qualifying bus cycle arrives.
- R11: Register reads return, one cycle after `reg_addr` is presented, the stored value. Control registers read back only bits [6:4] and [2:0], and the counter is zero-extended. Offsets are 0 CTRL0, 1 ADDR0, 2 CTRL1, 3 ADDR1, 4 MODE, 5 COUNT, 6 FLAGS.
- R12: Reset (synchronous, active high) clears all enables, flags, modes and the counter, and holds `brk_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus cycle present |
| bus_kind | input | 2 | 0 idle, 1 fetch, 2 read, 3 write |
| bus_addr | input | AW | Bus address |
| bus_blocked | input | 1 | CPU not accepting breaks |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Registered read data |
| brk_req | output | 1 | Break request pulse |
| brk_after | output | 1 | Break timing of the request (1 = after execution) |

## Verification
On every cycle, the assertions check the following: blocking suppresses the pulse, a pulse follows only a valid bus cycle with some channel enabled, flags stay set unless a zero is written to them, the counter never rises except through a register write, and reset clears state. Other behaviours depend on configuration history and appear only in the bench's scenarios. These are the kind-mask and address decode swept over all masks and kinds, `brk_after` priority, arming and disarming of the sequence in both orders, and the exact match on which the counter fires.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int RAW = 3;

  localparam logic [RAW-1:0] OFF_CTRL0 = 3'd0;
  localparam logic [RAW-1:0] OFF_ADDR0 = 3'd1;
  localparam logic [RAW-1:0] OFF_CTRL1 = 3'd2;
  localparam logic [RAW-1:0] OFF_ADDR1 = 3'd3;
  localparam logic [RAW-1:0] OFF_MODE  = 3'd4;
  localparam logic [RAW-1:0] OFF_COUNT = 3'd5;
  localparam logic [RAW-1:0] OFF_FLAGS = 3'd6;

  typedef enum logic [1:0] {
    KIND_IDLE  = 2'd0,
    KIND_FETCH = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } bus_kind_e;

  typedef struct packed {
    logic [2:0] kmask;  // bit0 fetch, bit1 read, bit2 write
    logic       after;
    logic       brk_en;
    logic       en;
  } chan_cfg_t;
endpackage

// File: rtl/brk_chan.sv
module brk_chan
  import brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  chan_cfg_t         cfg,
  input  logic [AW-1:0]     cmp_addr,
  input  logic              bus_valid,
  input  logic [1:0]        bus_kind,
  input  logic [AW-1:0]     bus_addr,
  output logic              hit
);
  logic kind_ok;

  always_comb begin
    unique case (bus_kind)
      KIND_FETCH: kind_ok = cfg.kmask[0];
      KIND_READ:  kind_ok = cfg.kmask[1];
      KIND_WRITE: kind_ok = cfg.kmask[2];
      default:    kind_ok = 1'b0;
    endcase
  end

  assign hit = cfg.en & bus_valid & kind_ok & (bus_addr == cmp_addr);
endmodule

// File: rtl/brk_count.sv
module brk_count #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          cnt_en,
  input  logic          dec_hit,
  output logic [CW-1:0] cnt,
  output logic          fire
);
  localparam logic [CW-1:0] ONE = CW'(1);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (cnt_en && dec_hit && cnt != '0)
      cnt <= cnt - ONE;
  end

  assign fire = cnt_en & dec_hit & (cnt == ONE);
endmodule

// File: rtl/brk_regs.sv
module brk_regs
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8,
  parameter int NCH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    reg_we,
  input  logic [RAW-1:0]          reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  input  logic [NCH-1:0]          flags,
  input  logic [CW-1:0]           cnt,
  output chan_cfg_t [NCH-1:0]     cfg,
  output logic [NCH-1:0][AW-1:0]  cmp_addr,
  output logic                    seq_en,
  output logic                    first_sel,
  output logic                    cnt_en,
  output logic [DW-1:0]           reg_rdata
);
  for (genvar c = 0; c < NCH; c++) begin : g_chreg
    localparam logic [RAW-1:0] CTRL_OFF = RAW'(2 * c);
    localparam logic [RAW-1:0] ADDR_OFF = RAW'(2 * c + 1);
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[c]      <= '0;
        cmp_addr[c] <= '0;
      end else if (reg_we) begin
        if (reg_addr == CTRL_OFF)
          cfg[c] <= '{kmask: reg_wdata[6:4], after: reg_wdata[2],
                      brk_en: reg_wdata[1], en: reg_wdata[0]};
        if (reg_addr == ADDR_OFF)
          cmp_addr[c] <= reg_wdata[AW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_en    <= 1'b0;
      first_sel <= 1'b0;
      cnt_en    <= 1'b0;
    end else if (reg_we && reg_addr == OFF_MODE) begin
      seq_en    <= reg_wdata[0];
      first_sel <= reg_wdata[1];
      cnt_en    <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else begin
      unique case (reg_addr)
        OFF_CTRL0: reg_rdata <= DW'({cfg[0].kmask, 1'b0, cfg[0].after, cfg[0].brk_en, cfg[0].en});
        OFF_ADDR0: reg_rdata <= DW'(cmp_addr[0]);
        OFF_CTRL1: reg_rdata <= DW'({cfg[1].kmask, 1'b0, cfg[1].after, cfg[1].brk_en, cfg[1].en});
        OFF_ADDR1: reg_rdata <= DW'(cmp_addr[1]);
        OFF_MODE:  reg_rdata <= DW'({cnt_en, first_sel, seq_en});
        OFF_COUNT: reg_rdata <= DW'(cnt);
        OFF_FLAGS: reg_rdata <= DW'(flags);
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/brk_unit.sv
module brk_unit
  import brk_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_valid,
  input  logic [1:0]     bus_kind,
  input  logic [AW-1:0]  bus_addr,
  input  logic           bus_blocked,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  output logic           brk_req,
  output logic           brk_after
);
  localparam int NCH = 2;

  chan_cfg_t [NCH-1:0]    cfg;
  logic [NCH-1:0][AW-1:0] cmp_addr;
  logic [NCH-1:0]         hit, req, ch_ok, ch_en;
  logic [NCH-1:0]         flag_q, flag_n;
  logic                   seq_en, first_sel, cnt_en, cnt_fire, flag_wr, cnt_load;
  logic [CW-1:0]          cnt_q;

  brk_regs #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) regs_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .flags(flag_q), .cnt(cnt_q), .cfg(cfg),
    .cmp_addr(cmp_addr), .seq_en(seq_en), .first_sel(first_sel),
    .cnt_en(cnt_en), .reg_rdata(reg_rdata)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    brk_chan #(.AW(AW)) chan_i (
      .cfg(cfg[c]), .cmp_addr(cmp_addr[c]), .bus_valid(bus_valid),
      .bus_kind(bus_kind), .bus_addr(bus_addr), .hit(hit[c])
    );
    assign ch_en[c] = cfg[c].en;
  end

  assign cnt_load = reg_we & (reg_addr == OFF_COUNT);

  brk_count #(.CW(CW)) count_i (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(reg_wdata[CW-1:0]),
    .cnt_en(cnt_en), .dec_hit(hit[1]), .cnt(cnt_q), .fire(cnt_fire)
  );

  assign ch_ok[0] = 1'b1;
  assign ch_ok[1] = ~cnt_en | cnt_fire;

  // Sequence: the first stage never requests; the second needs the first's flag.
  for (genvar c = 0; c < NCH; c++) begin : g_req
    logic is_first, armed;
    assign is_first = seq_en & (first_sel == 1'(c));
    assign armed    = ~seq_en | flag_q[first_sel];
    assign req[c]   = hit[c] & cfg[c].brk_en & ch_ok[c] & ~is_first & armed;
  end

  assign flag_wr = reg_we & (reg_addr == OFF_FLAGS);
  assign flag_n  = hit | (flag_q & ~({NCH{flag_wr}} & ~reg_wdata[NCH-1:0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q    <= '0;
      brk_req   <= 1'b0;
      brk_after <= 1'b0;
    end else begin
      flag_q    <= flag_n;
      brk_req   <= (|req) & ~bus_blocked;
      brk_after <= req[0] ? cfg[0].after : (req[1] & cfg[1].after);
    end
  end
endmodule

// File: rtl/brk_unit_chk.sv
module brk_unit_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_valid,
  input logic          bus_blocked,
  input logic          brk_req,
  input logic [1:0]    flag_q,
  input logic [1:0]    ch_en,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [1:0]    wd_lo,
  input logic [CW-1:0] cnt_q
);
  p_blocked_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    bus_blocked |=> !brk_req);

  p_pulse_after_bus_r10: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> ($past(bus_valid) && $past(ch_en) != 2'b00));

  p_flag0_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_q[0] && !(reg_we && reg_addr == 3'd6 && !wd_lo[0])) |=> flag_q[0]);

  p_flag1_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    (flag_q[1] && !(reg_we && reg_addr == 3'd6 && !wd_lo[1])) |=> flag_q[1]);

  p_cnt_no_rise_r9: assert property (@(posedge clk) disable iff (rst)
    !(reg_we && reg_addr == 3'd5) |=> (cnt_q <= $past(cnt_q)));

  p_reset_clear_r12: assert property (@(posedge clk)
    rst |=> (!brk_req && flag_q == 2'b00 && cnt_q == '0));
endmodule

bind brk_unit brk_unit_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_blocked(bus_blocked),
  .brk_req(brk_req), .flag_q(flag_q), .ch_en(ch_en), .reg_we(reg_we),
  .reg_addr(reg_addr), .wd_lo(reg_wdata[1:0]), .cnt_q(cnt_q)
);

// File: tb/brk_unit_tb_top.sv
`timescale 1ns/1ps
module brk_unit_tb_top;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 8;
  localparam logic [31:0] A0 = 32'h1000_0040;
  localparam logic [31:0] A1 = 32'h2000_0080;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0;
  logic [1:0] bus_kind = 2'd0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_blocked = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic brk_req, brk_after;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  brk_unit #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_kind(bus_kind),
    .bus_addr(bus_addr), .bus_blocked(bus_blocked), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .brk_req(brk_req), .brk_after(brk_after)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic bus(input logic [1:0] k, input logic [31:0] a, input logic blk,
                     output logic req, output logic aft);
    @(negedge clk);
    bus_valid = 1'b1; bus_kind = k; bus_addr = a; bus_blocked = blk;
    @(negedge clk);
    req = brk_req; aft = brk_after;
    bus_valid = 1'b0; bus_kind = 2'd0; bus_blocked = 1'b0;
  endtask

  initial begin
    logic [31:0] d;
    logic req, aft;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    chk("R12 brk_req after reset", 32'(brk_req), 0);
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), d);
      chk("R12 register zero after reset", d, 0);
    end
    bus(2'd1, 32'h0, 1'b0, req, aft);
    chk("R12 no break at reset config", 32'(req), 0);

    // R11: register readback
    wr(3'd1, A0);
    wr(3'd3, A1);
    rd(3'd1, d); chk("R11 ADDR0 readback", d, A0);
    rd(3'd3, d); chk("R11 ADDR1 readback", d, A1);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11 CTRL0 masked readback", d, 32'h77);
    wr(3'd5, 32'h1234_56A5);
    rd(3'd5, d); chk("R11 COUNT zero-extended", d, 32'hA5);
    wr(3'd5, 0);

    // R1/R2/R3: sweep kind mask x bus kind x address hit/miss on channel 0
    for (int m = 0; m < 8; m++) begin
      for (int k = 1; k < 4; k++) begin
        for (int h = 0; h < 2; h++) begin
          logic expv;
          expv = (h == 1) && m[k-1];
          wr(3'd0, 32'h3 | (32'(m) << 4));
          wr(3'd6, 0);
          bus(2'(k), (h == 1) ? A0 : A0 + 32'h4, 1'b0, req, aft);
          chk("R1 match decode request", 32'(req), 32'(expv));
          rd(3'd6, d);
          chk("R2 flag follows match", d, 32'(expv));
        end
      end
    end

    // R1: idle kind never matches
    wr(3'd0, 32'h73); wr(3'd6, 0);
    bus(2'd0, A0, 1'b0, req, aft);
    chk("R1 idle kind no request", 32'(req), 0);
    rd(3'd6, d); chk("R1 idle kind no flag", d, 0);

    // R1: disabled channel
    wr(3'd0, 32'h72);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R1 disabled no request", 32'(req), 0);
    rd(3'd6, d); chk("R1 disabled no flag", d, 0);

    // R3: request enable off, flag still set
    wr(3'd0, 32'h71);
    bus(2'd2, A0, 1'b0, req, aft);
    chk("R3 no request when disabled", 32'(req), 0);
    rd(3'd6, d); chk("R3 flag set without request", d, 1);

    // R2: writing 1 keeps flag; writing 0 clears
    wr(3'd6, 32'h3);
    rd(3'd6, d); chk("R2 write one no effect", d, 1);
    wr(3'd6, 32'h2);
    rd(3'd6, d); chk("R2 write zero clears", d, 0);

    // R4/R10: after bit and pulse width on channel 0
    wr(3'd0, 32'h77);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R10 pulse one cycle after bus", 32'(req), 1);
    chk("R4 after bit channel 0", 32'(aft), 1);
    @(negedge clk);
    chk("R10 pulse ends", 32'(brk_req), 0);

    // R4 channel 1 alone
    wr(3'd0, 32'h0); wr(3'd6, 0);
    wr(3'd2, 32'h77);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R4 channel 1 request", 32'(req), 1);
    chk("R4 after bit channel 1", 32'(aft), 1);

    // R5: both channels on the same address and cycle
    wr(3'd6, 0);
    wr(3'd1, A1);
    wr(3'd0, 32'h73);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R5 single request", 32'(req), 1);
    chk("R4 channel 0 priority", 32'(aft), 0);
    @(negedge clk);
    chk("R5 single pulse", 32'(brk_req), 0);
    rd(3'd6, d); chk("R5 both flags", d, 3);

    // R2: clear in the same cycle as a channel 0 hit keeps bit0
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 0;
    bus_valid = 1'b1; bus_kind = 2'd1; bus_addr = A0 + 32'h100;
    wr(3'd1, A0 + 32'h100);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 0;
    bus_valid = 1'b1; bus_kind = 2'd1; bus_addr = A0 + 32'h100;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0; bus_kind = 2'd0;
    rd(3'd6, d); chk("R2 hit beats clear", d, 1);
    wr(3'd1, A0);

    // R6: blocked
    wr(3'd6, 0);
    bus(2'd1, A0, 1'b1, req, aft);
    chk("R6 blocked no pulse", 32'(req), 0);
    rd(3'd6, d); chk("R6 flag while blocked", d, 1);

    // R7: sequence, channel 0 first
    wr(3'd6, 0);
    wr(3'd4, 32'h1);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R7 second stage unarmed", 32'(req), 0);
    rd(3'd6, d); chk("R7 second flag set unarmed", d, 2);
    wr(3'd6, 0);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R7 first stage silent", 32'(req), 0);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R7 armed second stage breaks", 32'(req), 1);
    // R8: clear first flag, disarm
    wr(3'd6, 32'h2);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R8 disarmed after clear", 32'(req), 0);

    // R7: sequence, channel 1 first
    wr(3'd6, 0);
    wr(3'd4, 32'h3);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R7 ch1-first ch0 unarmed", 32'(req), 0);
    bus(2'd3, A1, 1'b0, req, aft);
    chk("R7 ch1-first first stage silent", 32'(req), 0);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R7 ch1-first armed break", 32'(req), 1);
    wr(3'd6, 32'h1);
    bus(2'd1, A0, 1'b0, req, aft);
    chk("R8 ch1-first disarmed", 32'(req), 0);

    // R9: count mode on channel 1
    wr(3'd4, 32'h4);
    wr(3'd0, 32'h0);
    wr(3'd6, 0);
    wr(3'd5, 32'd3);
    for (int i = 0; i < 4; i++) begin
      bus(2'd3, A1, 1'b0, req, aft);
      chk("R9 fires on third match only", 32'(req), (i == 2) ? 1 : 0);
      rd(3'd5, d);
      chk("R9 counter value", d, (i < 3) ? 32'(2 - i) : 0);
    end
    rd(3'd6, d); chk("R9 flag set every match", d, 2);

    // R9: write beats decrement in the same cycle
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd5; reg_wdata = 32'd7;
    bus_valid = 1'b1; bus_kind = 2'd3; bus_addr = A1;
    @(negedge clk);
    reg_we = 1'b0; bus_valid = 1'b0; bus_kind = 2'd0;
    rd(3'd5, d); chk("R9 load priority", d, 7);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule